// File: doc/BRIEF.md
# Debug Memory Access Port

This block lets a debug host reach a 32-bit system memory bus through a small register window. The host sees a handful of 32-bit registers selected by an 8-bit offset. It sets the access size and the address stepping policy in a control word, and it loads a transfer address. Each read or write of the data register then becomes one memory-bus transfer at that address. After a transfer completes without error, the address can step forward by the access size. A host can therefore stream a run of consecutive locations while writing the address only once.

On the memory side, a request is held with a fixed address, byte strobes and write data until the bus acknowledges it. For byte and halfword accesses, the strobes are chosen from the low address bits. Write data is copied to every byte lane. Read data is taken from the addressed lane and returned right-justified. A few read-only registers identify the port and report which optional capabilities it has. A failed bus transfer is latched in a sticky flag that the host clears by writing to the control word.

Top module: `dbg_mem_port`

## Requirements
- R1: After reset, the control word reads 0x0000_0052: size 010 (word), step mode 01 (single), bit 6 (device enable) 1 and bit 7 (transfer in progress) 0. The transfer address reads 0 and `h_ready` is 1.
- R2: The size field, control word bits 2:0, accepts 000 (byte), 001 (halfword) and 010 (word). A write that carries any other code leaves the stored size unchanged.
- R3: The step field, control word bits 5:4, accepts 00 (address stays fixed) and 01 (single step). A write that carries 10 or 11 leaves the stored mode unchanged.
- R4: A host write to offset 0x0C raises `m_req` with `m_we`=1. The address is the transfer address with its two low bits cleared. For a byte access the strobe is one bit, selected by address bits 1:0. For a halfword access the strobe is 0011 or 1100, selected by address bit 1. For a word access the strobe is 1111. Write data is copied to every lane. The request and its fields stay unchanged, and `h_ready` stays 0, until `m_ack`.
- R5: A host read of offset 0x0C issues a read with the same address and strobes. When `h_ready` returns to 1, `h_rdata` holds the addressed byte or halfword, zero-extended, or the whole word.
- R6: In single mode, the transfer address grows by 1, 2 or 4 after each data access that completes without error. In fixed mode it does not change.
- R7: While a transfer is outstanding, control word bit 7 reads 1 and register reads are still served. Every host write is ignored.
- R8: A transfer acknowledged with `m_err` leaves the transfer address unchanged and sets control word bit 16. A control word write with bit 16 set clears that bit.
- R9: Offset 0xF8 reads the base address bits 31:12, with bits 1:0 both set (newer format, present). Offsets 0xF4, 0xF0, 0x08 and 0x20, and the banked offsets 0x10 to 0x1C, read 0, and writes to them have no effect.
- R10: Control word bits 31:23 and 14:8 read back as written. Bits 22:17, 15 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_off | input | 8 | Host register offset |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| h_ready | output | 1 | High when no memory transfer is outstanding |
| m_req | output | 1 | Memory request, held until acknowledge |
| m_we | output | 1 | Memory write enable |
| m_addr | output | 32 | Word-aligned memory address |
| m_be | output | DW/8 | Byte strobes |
| m_wdata | output | DW | Memory write data |
| m_rdata | input | DW | Memory read data |
| m_ack | input | 1 | Memory acknowledge |
| m_err | input | 1 | Memory error, valid with acknowledge |

## Verification
The hardest state to reach from the ports is the window in which a memory transfer is outstanding. In that window, polling, the busy flag and the discarding of host writes can be seen together. The bench holds back its modelled acknowledge for several cycles and, inside that window, reads the control word and attempts a transfer address write. After the acknowledge arrives, it reads the address back to confirm that only the single-mode step was applied. A second scenario returns an error acknowledge, confirms that the address stays put and the sticky flag is set, and then clears the flag through the control word.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  typedef enum logic [2:0] {SZ_BYTE = 3'd0, SZ_HALF = 3'd1, SZ_WORD = 3'd2} size_t;
  typedef enum logic [1:0] {INC_OFF = 2'd0, INC_ONE = 2'd1} inc_t;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_ADDR  = 8'h04;
  localparam logic [7:0] OFS_DATA  = 8'h0C;
  localparam logic [7:0] OFS_CAPS  = 8'hF4;
  localparam logic [7:0] OFS_ID    = 8'hF8;

  // control word bits that are plain storage (31:23, 14:8)
  localparam logic [31:0] ATTR_MASK = 32'hFF80_7F00;
  localparam int ERR_BIT  = 16;
  localparam int BUSY_BIT = 7;
  localparam int DEV_BIT  = 6;
endpackage

// File: rtl/dmp_lanes.sv
module dmp_lanes
  import dmp_pkg::*;
#(
  parameter int DW = 32
) (
  input  size_t                     size,
  input  logic [$clog2(DW/8)-1:0]   addr_lo,
  input  logic [31:0]               wdata,
  input  logic [DW-1:0]             rdata,
  output logic [DW/8-1:0]           be,
  output logic [DW-1:0]             wdata_rep,
  output logic [31:0]               rdata_ext
);
  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [OFF_W-1:0] base;
  logic [LANES-1:0] mask;
  logic [DW-1:0]    shifted;

  always_comb begin
    case (size)
      SZ_BYTE: begin base = addr_lo;                          mask = LANES'(1);  end
      SZ_HALF: begin base = {addr_lo[OFF_W-1:1], 1'b0};       mask = LANES'(3);  end
      default: begin base = {addr_lo[OFF_W-1:2], 2'b00};      mask = LANES'(15); end
    endcase
    be      = mask << base;
    shifted = rdata >> {base, 3'b000};
    case (size)
      SZ_BYTE: rdata_ext = {24'h0, shifted[7:0]};
      SZ_HALF: rdata_ext = {16'h0, shifted[15:0]};
      default: rdata_ext = shifted[31:0];
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      case (size)
        SZ_BYTE: wdata_rep[8*i +: 8] = wdata[7:0];
        SZ_HALF: wdata_rep[8*i +: 8] = wdata[8*(i%2) +: 8];
        default: wdata_rep[8*i +: 8] = wdata[8*(i%4) +: 8];
      endcase
    end
  end
endmodule

// File: rtl/dmp_csr.sv
module dmp_csr
  import dmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic        addr_we,
  input  logic [31:0] wdata,
  input  logic        step,
  input  logic        err_set,
  output size_t       size,
  output inc_t        inc,
  output logic [31:0] attr,
  output logic        err,
  output logic [31:0] tar
);
  logic [31:0] step_bytes;
  assign step_bytes = 32'(1) << size;

  always_ff @(posedge clk) begin
    if (rst) begin
      size <= SZ_WORD;
      inc  <= INC_ONE;
      attr <= '0;
      err  <= 1'b0;
      tar  <= '0;
    end else begin
      if (ctrl_we) begin
        attr <= wdata & ATTR_MASK;
        if (wdata[2:0] <= 3'd2) size <= size_t'(wdata[2:0]);
        if (wdata[5:4] <= 2'd1) inc  <= inc_t'(wdata[5:4]);
      end
      if (err_set)                      err <= 1'b1;
      else if (ctrl_we && wdata[ERR_BIT]) err <= 1'b0;
      if (addr_we)   tar <= wdata;
      else if (step) tar <= tar + step_bytes;
    end
  end
endmodule

// File: rtl/dmp_xfer.sv
module dmp_xfer #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            we,
  input  logic [31:0]     addr,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wdata,
  input  logic            m_ack,
  output logic            busy,
  output logic            done,
  output logic            m_req,
  output logic            m_we,
  output logic [31:0]     m_addr,
  output logic [DW/8-1:0] m_be,
  output logic [DW-1:0]   m_wdata
);
  localparam int OFF_W = $clog2(DW/8);

  assign busy = m_req;
  assign done = m_req & m_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_req   <= 1'b0;
      m_we    <= 1'b0;
      m_addr  <= '0;
      m_be    <= '0;
      m_wdata <= '0;
    end else if (!m_req) begin
      if (start) begin
        m_req   <= 1'b1;
        m_we    <= we;
        m_addr  <= {addr[31:OFF_W], {OFF_W{1'b0}}};
        m_be    <= be;
        m_wdata <= wdata;
      end
    end else if (m_ack) begin
      m_req <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port
  import dmp_pkg::*;
#(
  parameter int          DW        = 32,
  parameter logic [31:0] BASE_ADDR = 32'hE00F_F000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      h_off,
  input  logic            h_wr,
  input  logic            h_rd,
  input  logic [31:0]     h_wdata,
  output logic [31:0]     h_rdata,
  output logic            h_ready,
  output logic            m_req,
  output logic            m_we,
  output logic [31:0]     m_addr,
  output logic [DW/8-1:0] m_be,
  output logic [DW-1:0]   m_wdata,
  input  logic [DW-1:0]   m_rdata,
  input  logic            m_ack,
  input  logic            m_err
);
  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);

  size_t       cur_size;
  inc_t        cur_inc;
  logic [31:0] cur_attr;
  logic        cur_err;
  logic [31:0] cur_tar;
  logic        busy, done;
  logic [LANES-1:0] lane_be;
  logic [DW-1:0]    lane_wdata;
  logic [31:0]      lane_rdata;
  logic [31:0]      readback;

  logic idle, ctrl_we, addr_we, start;
  assign idle    = !busy;
  assign ctrl_we = idle && h_wr && (h_off == OFS_CTRL);
  assign addr_we = idle && h_wr && (h_off == OFS_ADDR);
  assign start   = idle && (h_wr || h_rd) && (h_off == OFS_DATA);

  dmp_csr u_csr (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .addr_we(addr_we), .wdata(h_wdata),
    .step(done && !m_err && (cur_inc == INC_ONE)), .err_set(done && m_err),
    .size(cur_size), .inc(cur_inc), .attr(cur_attr), .err(cur_err), .tar(cur_tar)
  );

  dmp_lanes #(.DW(DW)) u_lanes (
    .size(cur_size), .addr_lo(cur_tar[OFF_W-1:0]), .wdata(h_wdata), .rdata(m_rdata),
    .be(lane_be), .wdata_rep(lane_wdata), .rdata_ext(lane_rdata)
  );

  dmp_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst(rst), .start(start), .we(h_wr), .addr(cur_tar), .be(lane_be),
    .wdata(lane_wdata), .m_ack(m_ack), .busy(busy), .done(done), .m_req(m_req),
    .m_we(m_we), .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata)
  );

  always_comb begin
    case (h_off)
      OFS_CTRL: begin
        readback = cur_attr;
        readback[ERR_BIT]  = cur_err;
        readback[BUSY_BIT] = busy;
        readback[DEV_BIT]  = 1'b1;
        readback[5:4]      = cur_inc;
        readback[2:0]      = cur_size;
      end
      OFS_ADDR: readback = cur_tar;
      OFS_ID:   readback = {BASE_ADDR[31:12], 10'h0, 2'b11};
      OFS_CAPS: readback = 32'h0;
      default:  readback = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                                h_rdata <= '0;
    else if (done && !m_we)                 h_rdata <= lane_rdata;
    else if (h_rd && (h_off != OFS_DATA))   h_rdata <= readback;
  end

  assign h_ready = idle;
endmodule

// File: rtl/dmp_checks.sv
module dmp_checks
  import dmp_pkg::*;
#(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            h_ready,
  input logic            m_req,
  input logic            m_ack,
  input logic            m_err,
  input logic [31:0]     m_addr,
  input logic [DW/8-1:0] m_be,
  input size_t           size,
  input logic [31:0]     tar
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_be)); // R4
  AST_READY_LOW: assert property (@(posedge clk) disable iff (rst)
    m_req |-> !h_ready); // R4
  AST_BYTE_STROBE: assert property (@(posedge clk) disable iff (rst)
    m_req && size == SZ_BYTE |-> $countones(m_be) == 1); // R4
  AST_ERR_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
    m_req && m_ack && m_err |=> $stable(tar)); // R8
  AST_BUSY_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    m_req && !m_ack |=> $stable(tar)); // R7
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    size == SZ_BYTE || size == SZ_HALF || size == SZ_WORD); // R2
endmodule

bind dbg_mem_port dmp_checks #(.DW(DW)) u_checks (
  .clk(clk), .rst(rst), .h_ready(h_ready), .m_req(m_req), .m_ack(m_ack),
  .m_err(m_err), .m_addr(m_addr), .m_be(m_be), .size(cur_size), .tar(cur_tar)
);

// File: tb/dbg_mem_port_test.sv
module dbg_mem_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  h_off = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        h_ready;
  logic        m_req, m_we;
  logic [31:0] m_addr;
  logic [3:0]  m_be;
  logic [31:0] m_wdata;
  logic [31:0] m_rdata = '0;
  logic        m_ack = 1'b0, m_err = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dbg_mem_port uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] off, input logic [31:0] d);
    h_off = off; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] off, output logic [31:0] d);
    h_off = off; h_rd = 1'b1;
    @(negedge clk); h_rd = 1'b0;
    d = h_rdata;
  endtask

  // one data-register access with a modelled bus response
  task automatic data_xfer(input string tag, input logic wr, input logic [31:0] d,
                           input int delay, input logic err, input logic [31:0] mem,
                           input logic [31:0] exp_addr, input logic [3:0] exp_be,
                           input logic [31:0] exp_wd, output logic [31:0] rd);
    h_off = 8'h0C; h_wdata = d; h_wr = wr; h_rd = !wr;
    @(negedge clk); h_wr = 1'b0; h_rd = 1'b0;
    check({tag, " R4 req"}, {30'h0, m_req, m_we}, {30'h0, 1'b1, wr});
    check({tag, " R4 ready low"}, {31'h0, h_ready}, 32'h0);
    check({tag, " R4 addr"}, m_addr, exp_addr);
    check({tag, " R4 strobe"}, {28'h0, m_be}, {28'h0, exp_be});
    if (wr) check({tag, " R4 wdata"}, m_wdata, exp_wd);
    for (int i = 0; i < delay; i++) @(negedge clk);
    m_ack = 1'b1; m_err = err; m_rdata = mem;
    @(negedge clk);
    m_ack = 1'b0; m_err = 1'b0;
    check({tag, " R4 released"}, {30'h0, m_req, h_ready}, 32'h1);
    rd = h_rdata;
  endtask

  logic [31:0] v;

  task automatic t_reset;
    reg_rd(8'h00, v); check("R1 ctrl", v, 32'h0000_0052);
    reg_rd(8'h04, v); check("R1 addr", v, 32'h0);
    check("R1 ready", {31'h0, h_ready}, 32'h1);
  endtask

  task automatic t_word_write;
    reg_wr(8'h04, 32'h100);
    data_xfer("word wr", 1, 32'hA1B2C3D4, 1, 0, 0, 32'h100, 4'hF, 32'hA1B2C3D4, v);
    reg_rd(8'h04, v); check("R6 word step", v, 32'h104);
  endtask

  task automatic t_byte_write;
    reg_wr(8'h00, 32'h10);
    reg_wr(8'h04, 32'h203);
    data_xfer("byte wr", 1, 32'h0000005A, 0, 0, 0, 32'h200, 4'h8, 32'h5A5A5A5A, v);
    reg_rd(8'h04, v); check("R6 byte step", v, 32'h204);
  endtask

  task automatic t_half_read;
    reg_wr(8'h00, 32'h11);
    reg_wr(8'h04, 32'h302);
    data_xfer("half rd", 0, 0, 2, 0, 32'hBEEF1234, 32'h300, 4'hC, 0, v);
    check("R5 half data", v, 32'h0000BEEF);
    reg_rd(8'h04, v); check("R6 half step", v, 32'h304);
  endtask

  task automatic t_byte_read;
    reg_wr(8'h00, 32'h10);
    reg_wr(8'h04, 32'h401);
    data_xfer("byte rd", 0, 0, 1, 0, 32'h11223344, 32'h400, 4'h2, 0, v);
    check("R5 byte data", v, 32'h00000033);
  endtask

  task automatic t_fixed_mode;
    reg_wr(8'h00, 32'h02);
    reg_wr(8'h04, 32'h500);
    data_xfer("fixed rd1", 0, 0, 0, 0, 32'hCAFEF00D, 32'h500, 4'hF, 0, v);
    check("R5 word data", v, 32'hCAFEF00D);
    data_xfer("fixed rd2", 0, 0, 1, 0, 32'h12345678, 32'h500, 4'hF, 0, v);
    reg_rd(8'h04, v); check("R6 fixed addr", v, 32'h500);
  endtask

  task automatic t_illegal_codes;
    reg_wr(8'h00, 32'h33);
    reg_rd(8'h00, v); check("R2 R3 codes 011/11 kept", v, 32'h42);
    reg_wr(8'h00, 32'h24);
    reg_rd(8'h00, v); check("R2 R3 codes 100/10 kept", v, 32'h42);
  endtask

  task automatic t_bus_error;
    reg_wr(8'h00, 32'h12);
    reg_wr(8'h04, 32'h600);
    data_xfer("err wr", 1, 32'h1, 1, 1, 0, 32'h600, 4'hF, 32'h1, v);
    reg_rd(8'h04, v); check("R8 addr kept", v, 32'h600);
    reg_rd(8'h00, v); check("R8 sticky set", v, 32'h0001_0052);
    reg_wr(8'h00, 32'h0001_0012);
    reg_rd(8'h00, v); check("R8 sticky cleared", v, 32'h52);
  endtask

  task automatic t_busy_poll;
    h_off = 8'h0C; h_wdata = 32'h77; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
    reg_rd(8'h00, v); check("R7 busy bit", v, 32'hD2);
    reg_wr(8'h04, 32'h999);
    reg_wr(8'h00, 32'h0);
    check("R7 still waiting", {31'h0, m_req}, 32'h1);
    m_ack = 1'b1;
    @(negedge clk); m_ack = 1'b0;
    reg_rd(8'h04, v); check("R7 addr write ignored", v, 32'h604);
    reg_rd(8'h00, v); check("R7 ctrl write ignored", v, 32'h52);
  endtask

  task automatic t_ident;
    reg_rd(8'hF8, v); check("R9 id", v, 32'hE00F_F003);
    reg_rd(8'hF4, v); check("R9 caps", v, 32'h0);
    reg_wr(8'h08, 32'hFFFF_FFFF);
    reg_rd(8'h08, v); check("R9 upper addr", v, 32'h0);
    reg_wr(8'h20, 32'hFFFF_FFFF);
    reg_rd(8'h20, v); check("R9 barrier", v, 32'h0);
    reg_wr(8'h14, 32'hFFFF_FFFF);
    reg_rd(8'h14, v); check("R9 banked", v, 32'h0);
    reg_rd(8'hF0, v); check("R9 base2", v, 32'h0);
    reg_rd(8'h04, v); check("R9 addr untouched", v, 32'h604);
  endtask

  task automatic t_attr;
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, v); check("R10 attr all ones", v, 32'hFF80_7F52);
    reg_wr(8'h00, 32'h0);
    reg_rd(8'h00, v); check("R10 attr cleared", v, 32'h40);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word_write();
    t_byte_write();
    t_half_read();
    t_byte_read();
    t_fixed_mode();
    t_illegal_codes();
    t_bus_error();
    t_busy_poll();
    t_ident();
    t_attr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule